// File: doc/BRIEF.md
# Machine-Mode Trap Entry Unit

This block commits a trap for a 32-bit, single-hart core that has only two privilege levels, user and machine. When the pipeline raises a trap, it presents a one-cycle request with the cause code, a fault value, the program counter, the current privilege and the current status word. On that clock edge the block records the saved PC, the cause, the trap value and a rebuilt status word. It also forces the privilege to machine mode. In the same cycle it drives the redirect target taken from its trap-vector base register.

The trap-vector base and the four trap registers can also be loaded through a simple CSR write port. When a trap commits in the same cycle, the trap wins over any CSR write to the four trap registers. A CSR write to the vector base still completes, but the redirect in that cycle uses the old base. The all-ones cause code is reserved to mean "no trap". A request that carries it is dropped.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, the saved-PC, cause, trap-value, status and vector-base registers are zero, and the privilege output is 3 (machine).
- R2: A committed interrupt (cause bit 31 set) writes zero to the trap value and writes the request PC plus 4 to the saved PC.
- R3: A committed exception whose cause is 5 (load access fault) or 7 (store access fault) writes the request fault value to the trap value. The saved PC is the request PC.
- R4: Any other committed exception (causes 0, 1, 2, 3, 8, 11 and so on) writes the request PC to both the trap value and the saved PC.
- R5: A committed trap writes the request cause, unchanged, to the cause register.
- R6: A committed trap sets the status register as follows: bit 7 takes the old status bit 3, bits 12:11 take the request privilege, and every other bit is zero.
- R7: The privilege output becomes 3 on the edge after a committed trap. In cycles with no commit, it registers the `cur_priv` input.
- R8: While a valid request is present, `redirect_valid` is high in the same cycle and `redirect_pc` equals the vector-base register as it stood before the edge.
- R9: A request whose cause is 0xFFFFFFFF is ignored: `redirect_valid` stays low and no trap register changes.
- R10: CSR writes use the `csr_sel` encoding 0 = saved PC, 1 = cause, 2 = trap value, 3 = status, 4 = vector base. Writes to the vector base clear bits 1:0.
- R11: When a trap commits and a CSR write targets one of the four trap registers (select 0 to 3) in the same cycle, the trap values win.
- R12: A vector-base write in the same cycle as a trap does take effect, while that cycle's redirect uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_cause | input | 32 | Cause code; bit 31 marks an interrupt |
| trap_fault_val | input | 32 | Faulting address for load/store faults |
| cur_pc | input | 32 | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege (0 user, 3 machine) |
| cur_status | input | 32 | Current status word |
| csr_we | input | 1 | CSR write enable |
| csr_sel | input | 3 | CSR write target |
| csr_wdata | input | 32 | CSR write data |
| redirect_valid | output | 1 | Trap accepted this cycle |
| redirect_pc | output | 32 | Trap handler target |
| epc_q | output | 32 | Saved PC register |
| cause_q | output | 32 | Cause register |
| tval_q | output | 32 | Trap value register |
| status_q | output | 32 | Status register |
| tvec_q | output | 32 | Vector base register |
| priv_q | output | 2 | Privilege after this edge |

## Verification
The bench sweeps every exception code, several interrupt codes, both privilege levels and both settings of the enable bit, using PCs near the 32-bit wrap.

- A design that used the fault value for every exception, or for none, shows up on causes 5 and 7 against the rest.
- A design that forgot the plus 4, or the zeroed value, on interrupts shows up on the interrupt causes.
- Status mistakes show up as a leaked enable bit or a misplaced privilege field.
- The bench fires the reserved all-ones cause and checks that nothing moves.
- The bench collides CSR writes with traps on every select, which exposes wrong priority and a redirect that reads the new base.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN     = 32;
  localparam int INTR_BIT = XLEN - 1;
  localparam int MIE_BIT  = 3;
  localparam int MPIE_BIT = 7;
  localparam int MPP_LSB  = 11;
  localparam int PC_STEP  = 4;

  typedef logic [XLEN-1:0] word_t;

  localparam word_t      NO_TRAP           = '1;
  localparam word_t      CAUSE_LOAD_FAULT  = word_t'(5);
  localparam word_t      CAUSE_STORE_FAULT = word_t'(7);
  localparam logic [1:0] PRIV_U            = 2'd0;
  localparam logic [1:0] PRIV_M            = 2'd3;
  localparam word_t      TVEC_MASK         = ~word_t'(3);

  typedef enum logic [2:0] {
    SEL_EPC    = 3'd0,
    SEL_CAUSE  = 3'd1,
    SEL_TVAL   = 3'd2,
    SEL_STATUS = 3'd3,
    SEL_TVEC   = 3'd4
  } csr_sel_e;

  function automatic word_t saved_pc(input logic intr, input word_t pc);
    return intr ? pc + word_t'(PC_STEP) : pc;
  endfunction

  function automatic word_t trap_value(input logic intr, input logic mem_fault,
                                       input word_t pc, input word_t fault);
    if (intr)           return '0;
    else if (mem_fault) return fault;
    else                return pc;
  endfunction

  function automatic word_t status_after(input word_t st, input logic [1:0] prv);
    word_t ie;
    ie = (st >> MIE_BIT) & word_t'(1);
    return (ie << MPIE_BIT) | (word_t'(prv) << MPP_LSB);
  endfunction
endpackage

// File: rtl/trap_cause_decode.sv
module trap_cause_decode
  import trap_pkg::*;
(
  input  logic [XLEN-1:0] cause,
  output logic            is_intr,
  output logic            is_mem_fault,
  output logic            is_none
);
  always_comb begin
    is_none      = (cause == NO_TRAP);
    is_intr      = !is_none && cause[INTR_BIT];
    is_mem_fault = !is_none && ((cause == CAUSE_LOAD_FAULT) || (cause == CAUSE_STORE_FAULT));
  end
endmodule

// File: rtl/trap_csr_regs.sv
module trap_csr_regs
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [XLEN-1:0] new_epc,
  input  logic [XLEN-1:0] new_cause,
  input  logic [XLEN-1:0] new_tval,
  input  logic [XLEN-1:0] new_status,
  input  logic [1:0]      priv_in,
  input  logic            csr_we,
  input  logic [2:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] tval_q,
  output logic [XLEN-1:0] status_q,
  output logic [XLEN-1:0] tvec_q,
  output logic [1:0]      priv_q
);
  csr_sel_e sel;
  logic     sw_epc, sw_cause, sw_tval, sw_status, sw_tvec;

  always_comb begin
    sel       = csr_sel_e'(csr_sel);
    sw_epc    = csr_we && !commit && (sel == SEL_EPC);
    sw_cause  = csr_we && !commit && (sel == SEL_CAUSE);
    sw_tval   = csr_we && !commit && (sel == SEL_TVAL);
    sw_status = csr_we && !commit && (sel == SEL_STATUS);
    sw_tvec   = csr_we && (sel == SEL_TVEC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q    <= '0;
      cause_q  <= '0;
      tval_q   <= '0;
      status_q <= '0;
      tvec_q   <= '0;
      priv_q   <= PRIV_M;
    end else begin
      if (commit) begin
        epc_q    <= new_epc;
        cause_q  <= new_cause;
        tval_q   <= new_tval;
        status_q <= new_status;
        priv_q   <= PRIV_M;
      end else begin
        priv_q <= priv_in;
        if (sw_epc)    epc_q    <= csr_wdata;
        if (sw_cause)  cause_q  <= csr_wdata;
        if (sw_tval)   tval_q   <= csr_wdata;
        if (sw_status) status_q <= csr_wdata;
      end
      if (sw_tvec) tvec_q <= csr_wdata & TVEC_MASK;
    end
  end

  // R11
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && csr_we && csr_sel == 3'd0) |=> (epc_q == $past(new_epc)));
  // R10
  tvec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == 3'd4) |=> (tvec_q[1:0] == 2'b00));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trap_valid,
  input  logic [XLEN-1:0]      trap_cause,
  input  logic [XLEN-1:0]      trap_fault_val,
  input  logic [XLEN-1:0]      cur_pc,
  input  logic [1:0]           cur_priv,
  input  logic [XLEN-1:0]      cur_status,
  input  logic                 csr_we,
  input  logic [2:0]           csr_sel,
  input  logic [XLEN-1:0]      csr_wdata,
  output logic                 redirect_valid,
  output logic [XLEN-1:0]      redirect_pc,
  output logic [XLEN-1:0]      epc_q,
  output logic [XLEN-1:0]      cause_q,
  output logic [XLEN-1:0]      tval_q,
  output logic [XLEN-1:0]      status_q,
  output logic [XLEN-1:0]      tvec_q,
  output logic [1:0]           priv_q
);
  logic  is_intr, is_mem_fault, is_none;
  logic  trap_commit;
  word_t nx_epc, nx_tval, nx_status;

  trap_cause_decode u_dec (
    .cause        (trap_cause),
    .is_intr      (is_intr),
    .is_mem_fault (is_mem_fault),
    .is_none      (is_none)
  );

  always_comb begin
    trap_commit = trap_valid && !is_none;
    nx_epc      = saved_pc(is_intr, cur_pc);
    nx_tval     = trap_value(is_intr, is_mem_fault, cur_pc, trap_fault_val);
    nx_status   = status_after(cur_status, cur_priv);
  end

  trap_csr_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (trap_commit),
    .new_epc    (nx_epc),
    .new_cause  (trap_cause),
    .new_tval   (nx_tval),
    .new_status (nx_status),
    .priv_in    (cur_priv),
    .csr_we     (csr_we),
    .csr_sel    (csr_sel),
    .csr_wdata  (csr_wdata),
    .epc_q      (epc_q),
    .cause_q    (cause_q),
    .tval_q     (tval_q),
    .status_q   (status_q),
    .tvec_q     (tvec_q),
    .priv_q     (priv_q)
  );

  assign redirect_valid = trap_commit;
  assign redirect_pc    = tvec_q;

  // R2
  intr_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_cause[31] && trap_cause != '1)
      |=> (tval_q == '0 && epc_q == $past(cur_pc) + 32'd4));
  // R5
  cause_not_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (cause_q != '1));
  // R6
  status_ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (status_q[3] == 1'b0 && status_q[7] == $past(cur_status[3])));
  // R7
  priv_machine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (priv_q == 2'd3));
  // R9
  sentinel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_cause == '1 && !csr_we) |=> ($stable(cause_q) && $stable(epc_q)));
endmodule

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic [31:0] trap_cause = '0;
  logic [31:0] trap_fault_val = '0;
  logic [31:0] cur_pc = '0;
  logic [1:0]  cur_priv = 2'd0;
  logic [31:0] cur_status = '0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic        redirect_valid;
  logic [31:0] redirect_pc, epc_q, cause_q, tval_q, status_q, tvec_q;
  logic [1:0]  priv_q;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_unit uut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_csr(input logic [2:0] s, input logic [31:0] d);
    csr_we = 1'b1; csr_sel = s; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  // one trap at a negedge, checks before and after the edge
  task automatic do_trap(input logic [31:0] c, input logic [31:0] pc,
                         input logic [31:0] fv, input logic [1:0] p, input logic [31:0] st);
    logic        intr, mem;
    logic [31:0] tv, exp_epc, exp_tval, exp_st;
    tv = tvec_q;
    intr = c[31];
    mem  = (c == 32'd5) || (c == 32'd7);
    exp_epc  = intr ? pc + 32'd4 : pc;
    exp_tval = intr ? 32'd0 : (mem ? fv : pc);
    exp_st   = {19'd0, p, 3'd0, st[3], 7'd0};
    trap_valid = 1'b1; trap_cause = c; cur_pc = pc; trap_fault_val = fv;
    cur_priv = p; cur_status = st;
    #1;
    chk("R8", "redirect_valid", {31'd0, redirect_valid}, 32'd1);
    chk("R8", "redirect_pc", redirect_pc, tv);
    @(negedge clk);
    trap_valid = 1'b0;
    if (intr) chk("R2", "epc", epc_q, exp_epc);
    else if (mem) chk("R3", "epc", epc_q, exp_epc);
    else chk("R4", "epc", epc_q, exp_epc);
    if (intr) chk("R2", "tval", tval_q, exp_tval);
    else if (mem) chk("R3", "tval", tval_q, exp_tval);
    else chk("R4", "tval", tval_q, exp_tval);
    chk("R5", "cause", cause_q, c);
    chk("R6", "status", status_q, exp_st);
    chk("R7", "priv", {30'd0, priv_q}, 32'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] causes [14];
    logic [31:0] pcs [3];
    logic [31:0] snap_e, snap_c, snap_t, snap_s;
    causes = '{32'd0, 32'd1, 32'd2, 32'd3, 32'd5, 32'd7, 32'd8, 32'd11, 32'd4, 32'd6,
               32'h8000_0007, 32'h8000_0003, 32'h8000_000B, 32'h8000_0005};
    pcs = '{32'h0000_1000, 32'hFFFF_FFFC, 32'h8000_0124};
    cur_status = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset values
    chk("R1", "epc", epc_q, 32'd0);
    chk("R1", "cause", cause_q, 32'd0);
    chk("R1", "tval", tval_q, 32'd0);
    chk("R1", "status", status_q, 32'd0);
    chk("R1", "tvec", tvec_q, 32'd0);
    chk("R1", "priv", {30'd0, priv_q}, 32'd3);
    chk("R8", "idle redirect_valid", {31'd0, redirect_valid}, 32'd0);
    @(negedge clk);
    // R10 tvec alignment
    write_csr(3'd4, 32'h2000_0103);
    chk("R10", "tvec align", tvec_q, 32'h2000_0100);

    // sweep
    for (int ci = 0; ci < 14; ci++)
      for (int pi = 0; pi < 3; pi++)
        for (int pr = 0; pr < 2; pr++)
          for (int ie = 0; ie < 2; ie++) begin
            do_trap(causes[ci], pcs[pi], 32'hDEAD_0000 ^ (ci << 8) ^ pi,
                    pr ? 2'd3 : 2'd0, ie ? 32'hA5A5_5A5A | 32'h8 : 32'h5A5A_A5A5 & ~32'h8);
          end

    // R7 follow cur_priv without trap
    cur_priv = 2'd0;
    @(negedge clk);
    chk("R7", "priv follows", {30'd0, priv_q}, 32'd0);

    // R10 writes to each trap register
    write_csr(3'd0, 32'h1111_0000); chk("R10", "epc write", epc_q, 32'h1111_0000);
    write_csr(3'd1, 32'h2222_0000); chk("R10", "cause write", cause_q, 32'h2222_0000);
    write_csr(3'd2, 32'h3333_0000); chk("R10", "tval write", tval_q, 32'h3333_0000);
    write_csr(3'd3, 32'h4444_0000); chk("R10", "status write", status_q, 32'h4444_0000);

    // R9 sentinel ignored
    snap_e = epc_q; snap_c = cause_q; snap_t = tval_q; snap_s = status_q;
    trap_valid = 1'b1; trap_cause = 32'hFFFF_FFFF; cur_pc = 32'h0BAD_0000; cur_priv = 2'd0;
    #1;
    chk("R9", "redirect_valid", {31'd0, redirect_valid}, 32'd0);
    @(negedge clk);
    trap_valid = 1'b0;
    chk("R9", "epc", epc_q, snap_e);
    chk("R9", "cause", cause_q, snap_c);
    chk("R9", "tval", tval_q, snap_t);
    chk("R9", "status", status_q, snap_s);
    chk("R9", "priv", {30'd0, priv_q}, 32'd0);

    // R11 collisions: trap beats CSR write for selects 0..3
    for (int s = 0; s < 4; s++) begin
      csr_we = 1'b1; csr_sel = 3'(s); csr_wdata = 32'hCAFE_F00D;
      do_trap(32'd2, 32'h0000_4000 + 32'(s*4), 32'd0, 2'd0, 32'h8);
      csr_we = 1'b0;
      chk("R11", "no csr leak epc", epc_q, 32'h0000_4000 + 32'(s*4));
    end

    // R12 tvec write with trap
    csr_we = 1'b1; csr_sel = 3'd4; csr_wdata = 32'h0000_8000;
    do_trap(32'h8000_0007, 32'h0000_5000, 32'd0, 2'd3, 32'd0);
    csr_we = 1'b0;
    chk("R12", "tvec updated", tvec_q, 32'h0000_8000);
    trap_valid = 1'b1; trap_cause = 32'd3; #1;
    chk("R12", "redirect new tvec", redirect_pc, 32'h0000_8000);
    @(negedge clk);
    trap_valid = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule